// File: doc/BRIEF.md
# Paged Conditional Jump Unit

This block is the program-counter section of a small 4-bit processor core. The counter has three fields: a one-bit bank, a 4-bit page and an 8-bit step. Ordinary instructions advance only the step field. Jumps across pages use two instructions. First, a page-select instruction loads a pending bank and a pending page into a pair of staging registers. Later, a jump-on-zero instruction moves those staged values into the counter, together with an 8-bit target taken from its own low byte. The jump goes ahead only if the zero flag is set.

The unit takes one 12-bit instruction word for each strobe of `instr_valid_i`, and it samples `zero_i` on the edge that accepts the word. A jump-on-zero occupies the unit for five cycles whether it is taken or not. During those cycles `busy_o` is high, the counter fields hold their values, and incoming strobes are dropped. The control is a three-state sequencer:

- `SEQ_IDLE`: accepts instructions.
- `SEQ_HOLD`: counts down the wait with a small counter.
- `SEQ_COMMIT`: the final busy cycle, whose closing edge writes the counter.

Its transitions are:

- IDLE to HOLD on an accepted jump.
- HOLD to HOLD while the count is non-zero.
- HOLD to COMMIT when the count reaches zero.
- COMMIT to IDLE always.

Top module: `pcj_unit`

## Requirements
- R1: While `rst_n` is low and just after it is released, bank, page and step read zero, `busy_o` is low, and the staged bank and page are zero.
- R2: An instruction accepted while idle that is neither a jump nor a page select (for example 123H, 700H, E60H, E3FH) increments step by one on the next edge. Bank and page stay unchanged and `busy_o` stays low.
- R3: The step field wraps from FFH to 00H without changing bank or page.
- R4: A page select is any word whose bits [11:5] equal 1110010 (E40H to E5FH). Bit 4 loads the staged bank and bits [3:0] load the staged page. The visible bank and page do not change, and step increments by one. For example, E5BH stages bank 1 and page 1011.
- R5: A jump-on-zero is any word whose bits [11:8] equal 0110, with its target in bits [7:0]. If `zero_i` was 1 when it was accepted, then when it completes bank takes the staged bank, page takes the staged page, and step takes the target.
- R6: If `zero_i` was 0 when a jump was accepted, then when it completes step is one more than before the jump, and bank and page are unchanged.
- R7: `busy_o` rises on the edge that accepts a jump and stays high for exactly 5 cycles. The counter fields change only on the edge where `busy_o` falls, and they hold their values while `busy_o` is high.
- R8: `zero_i` is used only on the accepting edge. Changes to it while busy have no effect on the outcome.
- R9: Strobes that arrive while `busy_o` is high are ignored. This includes page selects and jumps: they neither stage values nor advance step.
- R10: The staged bank and page keep their values after a jump and serve later jumps until the next page select.
- R11: With no strobe while idle, all counter fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 12 | Instruction word |
| instr_valid_i | input | 1 | Instruction strobe, used only when not busy |
| zero_i | input | 1 | Zero flag, sampled when a jump is accepted |
| bank_o | output | 1 | Bank field of the counter |
| page_o | output | 4 | Page field of the counter |
| step_o | output | 8 | Step field of the counter |
| busy_o | output | 1 | High during the five cycles of a jump |

## Verification
The bound checker watches several behaviours on every cycle:

- the busy window has exactly the jump length, and the counter is frozen inside it;
- an idle unit with no strobe holds its counter, and an ordinary accepted word increments step;
- a finished jump, whether taken or not, lands on the value implied by the latest accepted page select and the word that started it.

Some behaviours only the bench scenarios can show:

- the exact decode boundaries, using near-miss words such as E3FH, E60H and 700H;
- that zero flips and page-select or jump strobes during a busy window leave no trace in the next jump's result;
- reuse of staged values across several jumps;
- the FFH-to-00H wrap after a jump lands near the top of a page.

// File: rtl/pcj_pkg.sv
package pcj_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HOLD   = 2'd1,
        SEQ_COMMIT = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PLAIN   = 2'd0,
        OP_PAGESET = 2'd1,
        OP_JUMPZ   = 2'd2
    } op_kind_t;

    localparam logic [3:0] JUMPZ_CODE   = 4'b0110;
    localparam logic [6:0] PAGESET_CODE = 7'b1110010;

endpackage

// File: rtl/pcj_decode.sv
module pcj_decode
    import pcj_pkg::*;
#(
    parameter int INSTR_W = 12,
    parameter int STEP_W  = 8,
    parameter int PAGE_W  = 4
) (
    input  logic [INSTR_W-1:0] instr_i,
    output op_kind_t           kind_o,
    output logic [STEP_W-1:0]  target_o,
    output logic               set_bank_o,
    output logic [PAGE_W-1:0]  set_page_o
);
    localparam int MAJ_W = 4;
    localparam int PS_W  = INSTR_W - PAGE_W - 1;

    logic [MAJ_W-1:0] major;
    logic [PS_W-1:0]  ps_field;

    assign major    = instr_i[INSTR_W-1 -: MAJ_W];
    assign ps_field = instr_i[INSTR_W-1 : PAGE_W+1];

    always_comb begin
        if (major == JUMPZ_CODE) begin
            kind_o = OP_JUMPZ;
        end else if (ps_field == PS_W'(PAGESET_CODE)) begin
            kind_o = OP_PAGESET;
        end else begin
            kind_o = OP_PLAIN;
        end
    end

    assign target_o   = instr_i[STEP_W-1:0];
    assign set_bank_o = instr_i[PAGE_W];
    assign set_page_o = instr_i[PAGE_W-1:0];

endmodule

// File: rtl/pcj_seq.sv
module pcj_seq
    import pcj_pkg::*;
#(
    parameter int JUMP_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic commit_o
);
    localparam int CNT_W = (JUMP_CYCLES > 2) ? $clog2(JUMP_CYCLES - 1) : 1;
    localparam logic [CNT_W-1:0] HOLD_INIT = CNT_W'(JUMP_CYCLES - 2);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    state_d = SEQ_HOLD;
                    cnt_d   = HOLD_INIT;
                end
            end
            SEQ_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = SEQ_COMMIT;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SEQ_COMMIT: begin
                state_d = SEQ_IDLE;
            end
            default: begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy_o   = 1'b0;
        commit_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   busy_o = 1'b0;
            SEQ_HOLD:   busy_o = 1'b1;
            SEQ_COMMIT: begin
                busy_o   = 1'b1;
                commit_o = 1'b1;
            end
            default:    busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcj_next_page.sv
module pcj_next_page #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              bank_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              bank_o,
    output logic [PAGE_W-1:0] page_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_o <= 1'b0;
            page_o <= '0;
        end else if (load_i) begin
            bank_o <= bank_i;
            page_o <= page_i;
        end
    end
endmodule

// File: rtl/pcj_pc_reg.sv
module pcj_pc_reg #(
    parameter int PAGE_W = 4,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              load_i,
    input  logic              bank_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              bank_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [STEP_W-1:0] step_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_o <= 1'b0;
            page_o <= '0;
            step_o <= '0;
        end else if (load_i) begin
            bank_o <= bank_i;
            page_o <= page_i;
            step_o <= step_i;
        end else if (adv_i) begin
            step_o <= step_o + 1'b1;
        end
    end
endmodule

// File: rtl/pcj_unit.sv
module pcj_unit
    import pcj_pkg::*;
#(
    parameter int INSTR_W     = 12,
    parameter int STEP_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int JUMP_CYCLES = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               instr_valid_i,
    input  logic               zero_i,
    output logic               bank_o,
    output logic [PAGE_W-1:0]  page_o,
    output logic [STEP_W-1:0]  step_o,
    output logic               busy_o
);
    op_kind_t          kind;
    logic [STEP_W-1:0] dec_target;
    logic              dec_bank;
    logic [PAGE_W-1:0] dec_page;
    logic              accept;
    logic              start_jump;
    logic              commit;
    logic              stage_bank;
    logic [PAGE_W-1:0] stage_page;
    logic              taken_q;
    logic [STEP_W-1:0] target_q;
    logic              pc_adv;
    logic              pc_load;

    pcj_decode #(
        .INSTR_W (INSTR_W),
        .STEP_W  (STEP_W),
        .PAGE_W  (PAGE_W)
    ) dec_i (
        .instr_i    (instr_i),
        .kind_o     (kind),
        .target_o   (dec_target),
        .set_bank_o (dec_bank),
        .set_page_o (dec_page)
    );

    assign accept     = instr_valid_i && !busy_o;
    assign start_jump = accept && (kind == OP_JUMPZ);

    pcj_seq #(
        .JUMP_CYCLES (JUMP_CYCLES)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_jump),
        .busy_o   (busy_o),
        .commit_o (commit)
    );

    pcj_next_page #(
        .PAGE_W (PAGE_W)
    ) stage_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept && (kind == OP_PAGESET)),
        .bank_i (dec_bank),
        .page_i (dec_page),
        .bank_o (stage_bank),
        .page_o (stage_page)
    );

    // condition and target frozen at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q  <= 1'b0;
            target_q <= '0;
        end else if (start_jump) begin
            taken_q  <= zero_i;
            target_q <= dec_target;
        end
    end

    assign pc_adv  = (accept && (kind != OP_JUMPZ)) || (commit && !taken_q);
    assign pc_load = commit && taken_q;

    pcj_pc_reg #(
        .PAGE_W (PAGE_W),
        .STEP_W (STEP_W)
    ) pc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (pc_adv),
        .load_i (pc_load),
        .bank_i (stage_bank),
        .page_i (stage_page),
        .step_i (target_q),
        .bank_o (bank_o),
        .page_o (page_o),
        .step_o (step_o)
    );

endmodule

// File: rtl/pcj_unit_checker.sv
module pcj_unit_checker #(
    parameter int INSTR_W     = 12,
    parameter int STEP_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int JUMP_CYCLES = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr_i,
    input logic               instr_valid_i,
    input logic               zero_i,
    input logic               bank_o,
    input logic [PAGE_W-1:0]  page_o,
    input logic [STEP_W-1:0]  step_o,
    input logic               busy_o
);
    localparam int RUN_W = $clog2(JUMP_CYCLES + 1) + 1;

    logic              is_jump;
    logic              is_pset;
    logic [RUN_W-1:0]  run;
    logic              t_nb;
    logic [PAGE_W-1:0] t_np;
    logic              t_taken;
    logic [STEP_W-1:0] t_tgt;
    logic [STEP_W-1:0] t_step0;
    logic              t_bank0;
    logic [PAGE_W-1:0] t_page0;

    assign is_jump = instr_i[INSTR_W-1 -: 4] == 4'b0110;
    assign is_pset = instr_i[INSTR_W-1 : PAGE_W+1] == (INSTR_W-PAGE_W-1)'(7'b1110010);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= '0;
            t_nb    <= 1'b0;
            t_np    <= '0;
            t_taken <= 1'b0;
            t_tgt   <= '0;
            t_step0 <= '0;
            t_bank0 <= 1'b0;
            t_page0 <= '0;
        end else begin
            run <= busy_o ? run + 1'b1 : '0;
            if (instr_valid_i && !busy_o && is_pset) begin
                t_nb <= instr_i[PAGE_W];
                t_np <= instr_i[PAGE_W-1:0];
            end
            if (instr_valid_i && !busy_o && is_jump) begin
                t_taken <= zero_i;
                t_tgt   <= instr_i[STEP_W-1:0];
                t_step0 <= step_o;
                t_bank0 <= bank_o;
                t_page0 <= page_o;
            end
        end
    end

    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && !busy_o && is_jump) |=> busy_o);

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run < RUN_W'(JUMP_CYCLES)));

    assert_busy_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(busy_o)) |-> ($past(run) == RUN_W'(JUMP_CYCLES - 1)));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(step_o) && $stable(page_o) && $stable(bank_o))));

    // also covers the wrap of R3
    assert_plain_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && !busy_o && !is_jump) |=>
        (step_o == STEP_W'($past(step_o) + 1'b1) && $stable(page_o) && $stable(bank_o) && !busy_o));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid_i && !busy_o) |=>
        ($stable(step_o) && $stable(page_o) && $stable(bank_o)));

    assert_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(busy_o) && t_taken) |->
        (bank_o == t_nb && page_o == t_np && step_o == t_tgt));

    assert_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(busy_o) && !t_taken) |->
        (bank_o == t_bank0 && page_o == t_page0 && step_o == STEP_W'(t_step0 + 1'b1)));

endmodule

bind pcj_unit pcj_unit_checker #(
    .INSTR_W     (INSTR_W),
    .STEP_W      (STEP_W),
    .PAGE_W      (PAGE_W),
    .JUMP_CYCLES (JUMP_CYCLES)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_valid_i (instr_valid_i),
    .zero_i        (zero_i),
    .bank_o        (bank_o),
    .page_o        (page_o),
    .step_o        (step_o),
    .busy_o        (busy_o)
);

// File: tb/pcj_unit_tb_top.sv
module pcj_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] instr_i = '0;
    logic        instr_valid_i = 1'b0;
    logic        zero_i = 1'b0;
    logic        bank_o;
    logic [3:0]  page_o;
    logic [7:0]  step_o;
    logic        busy_o;

    always #5 clk = ~clk;

    pcj_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr_i),
        .instr_valid_i (instr_valid_i),
        .zero_i        (zero_i),
        .bank_o        (bank_o),
        .page_o        (page_o),
        .step_o        (step_o),
        .busy_o        (busy_o)
    );

    typedef struct {
        int         due;
        logic       bank;
        logic [3:0] page;
        logic [7:0] step;
        logic       busy;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   total = 0;
    int   fails = 0;
    bit   done = 0;

    // reference model state
    logic       m_bank = 0, m_nb = 0, m_taken = 0;
    logic [3:0] m_page = 0, m_np = 0;
    logic [7:0] m_step = 0, m_tgt = 0;
    int         m_left = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic b, input logic [3:0] p,
                         input logic [7:0] s, input logic bz);
        total++;
        if (bank_o !== b || page_o !== p || step_o !== s || busy_o !== bz) begin
            fails++;
            $display("FAIL %s: got bank=%0d page=%h step=%h busy=%0d, expected bank=%0d page=%h step=%h busy=%0d",
                     tag, bank_o, page_o, step_o, busy_o, b, p, s, bz);
        end
    endtask

    // monitor: compares outputs against due expectations
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, e.bank, e.page, e.step, e.busy);
        end
    end

    // driver: one cycle of stimulus, model update, expectation push
    task automatic tick(input logic v, input logic [11:0] ins, input logic z, input string tag);
        exp_t e;
        @(negedge clk);
        instr_valid_i = v;
        instr_i       = ins;
        zero_i        = z;
        if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                if (m_taken) begin
                    m_bank = m_nb;
                    m_page = m_np;
                    m_step = m_tgt;
                end else begin
                    m_step = m_step + 8'd1;
                end
            end
        end else if (v) begin
            if (ins[11:8] == 4'b0110) begin
                m_left  = 5;
                m_taken = z;
                m_tgt   = ins[7:0];
            end else if (ins[11:5] == 7'b1110010) begin
                m_nb   = ins[4];
                m_np   = ins[3:0];
                m_step = m_step + 8'd1;
            end else begin
                m_step = m_step + 8'd1;
            end
        end
        e.due  = cyc + 1;
        e.bank = m_bank;
        e.page = m_page;
        e.step = m_step;
        e.busy = (m_left > 0);
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic jump_run(input logic [11:0] ins, input logic z, input string tag);
        tick(1, ins, z, "R7");
        tick(0, 12'h000, !z, "R8");
        tick(1, 12'hE4A, z, "R9");
        tick(1, 12'h6CC, !z, "R9");
        tick(1, 12'h222, z, "R9");
        tick(0, 12'h000, z, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 4'h0, 8'h00, 1'b0);
        rst_n = 1'b1;
        // R1: staged registers start at zero
        tick(1, 12'h655, 1, "R1");
        repeat (5) tick(0, 12'h000, 0, "R1");
        tick(1, 12'h123, 0, "R2");
        tick(1, 12'h7AB, 1, "R2");
        tick(1, 12'h700, 0, "R2");
        tick(0, 12'h6FF, 1, "R11");
        tick(0, 12'hE5B, 0, "R11");
        tick(1, 12'hE5B, 0, "R4");
        jump_run(12'h610, 1, "R5");
        jump_run(12'h6AA, 0, "R6");
        jump_run(12'h6F0, 1, "R10");
        tick(1, 12'hE45, 0, "R4");
        jump_run(12'h6FE, 1, "R5");
        tick(1, 12'h3C3, 0, "R3");
        tick(1, 12'h0F0, 0, "R3");
        tick(1, 12'hE60, 0, "R2");
        tick(1, 12'hE3F, 0, "R2");
        jump_run(12'h620, 1, "R4");
        jump_run(12'h6FF, 0, "R6");
        tick(0, 12'h000, 0, "R11");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule